// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Almost-Empty Flag

This block is a first-in first-out buffer for 9-bit words. The producer and the consumer run on unrelated clocks. Writes are taken on `wrClk` and reads on `rdClk`. A static mode input selects one of two read styles:

- **Standard mode:** the read port shows a word only after an explicit read.
- **Fall-through mode:** the oldest word moves into the output register by itself, so it can be taken as soon as `rdReady` is high.

In both modes a read-domain `almostEmpty` flag compares the number of words in the memory array with a programmable offset. In fall-through mode the word waiting in the output register has already left memory, so it is not part of that number.

The almost-empty offset and a second, held-only almost-full offset are each 18 bits wide. Each is split into a low and a high word, and both are reached through the normal data path. While `cfgAccess` is high:

- every enabled write stores `wrData` into the current offset part;
- every enabled read presents the current part on `rdData`;
- a small sequencer steps through the four parts in turn.

The offsets are configuration state. They are meant to be changed only while the data path is idle.

Top module: `xclk_fifo`

## Requirements
- R1: After reset, `rdReady`, `full` and `rdData` are 0 and `almostEmpty` is 1.
- R2: Data words leave the FIFO in the order they were written, in both modes.
- R3: `full` is high while the memory array holds DEPTH words. A data write while `full` is high is dropped and does not disturb stored data.
- R4: In standard mode, `rdReady` is high while memory is non-empty. `rdData` changes only after a read with `rdEn` high and `cfgAccess` low on a non-empty FIFO. A read on an empty FIFO leaves `rdData` unchanged.
- R5: In fall-through mode, a word written into an empty FIFO appears on `rdData`, with `rdReady` high, within four `rdClk` rising edges after the writing edge, and no read is needed. A read with `rdEn` high consumes it, and `rdReady` drops when nothing follows.
- R6: `almostEmpty` is 1 while the memory count is at most the almost-empty offset, and 0 once it is offset+1 or more. The word held in the fall-through output register is excluded from that count.
- R7: After a write that lifts the count above the offset, `almostEmpty` falls within four `rdClk` rising edges. After a read it reflects the new count right after that read edge.
- R8: After reset both offsets are 127. The read-back order of the parts is:
  - part 0: almost-empty bits 8:0
  - part 1: almost-empty bits 17:9
  - part 2: almost-full bits 8:0
  - part 3: almost-full bits 17:9

  This holds in both modes.
- R9: A write with `cfgAccess` and `wrEn` high stores `wrData` into the current part and advances the sequence. Nothing enters the FIFO.
- R10: Each domain's part sequence returns to part 0 after the fourth access, and after any of its clock edges with `cfgAccess` low.
- R11: A read with `cfgAccess` and `rdEn` high shows the current part on `rdData` after that `rdClk` edge. It consumes no FIFO data, and the value stays until the next word enters the output register.
- R12: While `outEn` is low, `rdData` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrClk | input | 1 | Write-side clock |
| rdClk | input | 1 | Read-side clock |
| rstN | input | 1 | Asynchronous reset for both domains, active low |
| fallThrough | input | 1 | 1 selects fall-through mode; held static outside reset |
| cfgAccess | input | 1 | 1 routes enabled writes and reads to the offset parts |
| wrEn | input | 1 | Write enable |
| wrData | input | DATA_W | Write data, or an offset part during configuration |
| rdEn | input | 1 | Read enable |
| outEn | input | 1 | 1 drives the output word, 0 forces zero |
| rdData | output | DATA_W | Output word or offset part |
| rdReady | output | 1 | Standard mode: memory non-empty. Fall-through mode: output word valid |
| almostEmpty | output | 1 | Memory count at or below the almost-empty offset |
| full | output | 1 | Memory array full |

## Verification
The bound checker watches, on every edge of its domain, the properties that hold cycle by cycle:

- pointers freeze on a write at `full`, on a read from an empty array, and during configuration access;
- Gray pointers change at most one bit per edge;
- the read-side count never exceeds the depth;
- the standard-mode output holds when there is no read;
- a fall-through word only appears when memory had one.

Data ordering, the exact `almostEmpty` threshold with the output word excluded, crossing latency, the order and wrap of the offset parts, and output gating depend on sequences and stored values. Only the bench's sweeps over a 16-word configuration in both modes can show those.

// File: rtl/xclk_fifo_pkg.sv
package xclk_fifo_pkg;

  // Offset part selected by the configuration sequencer; order is behaviour.
  typedef enum logic [1:0] {
    PART_AE_LO = 2'd0,
    PART_AE_HI = 2'd1,
    PART_AF_LO = 2'd2,
    PART_AF_HI = 2'd3
  } offPart_e;

  // Strobes from control to datapath.
  typedef struct packed {
    logic push;   // write-domain: store wrData into memory
    logic cfgWr;  // write-domain: store wrData into offset part
    logic pop;    // read-domain: move head word into output register
    logic cfgRd;  // read-domain: show offset part on output
  } fifoStrobe_t;

endpackage

// File: rtl/xclk_fifo_sync.sv
module xclk_fifo_sync #(
  parameter int W      = 5,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stage [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < STAGES; i++) stage[i] <= '0;
    end else begin
      stage[0] <= d;
      for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
    end
  end

  assign q = stage[STAGES-1];

endmodule

// File: rtl/xclk_fifo_ctrl.sv
module xclk_fifo_ctrl
  import xclk_fifo_pkg::*;
#(
  parameter int DEPTH     = 1024,
  parameter int AW        = $clog2(DEPTH),
  parameter int PTR_W     = AW + 1,
  parameter int OFF_W     = 18,
  parameter int SYNC_LEN  = 2
) (
  input  logic             wrClk,
  input  logic             rdClk,
  input  logic             rstN,
  input  logic             fallThrough,
  input  logic             cfgAccess,
  input  logic             wrEn,
  input  logic             rdEn,
  input  logic [OFF_W-1:0] aeOffset,
  output fifoStrobe_t      strobe,
  output logic [AW-1:0]    wrAddr,
  output logic [AW-1:0]    rdAddr,
  output offPart_e         wrPart,
  output offPart_e         rdPart,
  output logic [PTR_W-1:0] wrPtr,
  output logic [PTR_W-1:0] rdPtr,
  output logic [PTR_W-1:0] wrGray,
  output logic [PTR_W-1:0] rdGray,
  output logic [PTR_W-1:0] memCount,
  output logic             full,
  output logic             rdReady,
  output logic             almostEmpty
);

  localparam int CMP_W = (PTR_W > OFF_W) ? PTR_W : OFF_W;

  function automatic logic [PTR_W-1:0] grayToBin(input logic [PTR_W-1:0] g);
    logic [PTR_W-1:0] b;
    b[PTR_W-1] = g[PTR_W-1];
    for (int i = PTR_W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [PTR_W-1:0] wrBin, wrBinNext, rdBin, rdBinNext;
  logic [PTR_W-1:0] wrGrayQ, rdGrayQ;
  logic [PTR_W-1:0] rdGraySync, wrGraySync, wrBinSync;
  logic             outValid, dataRead, memEmpty, pushNow, popNow;

  // ---------------- write domain ----------------
  assign pushNow   = wrEn && !cfgAccess && !full;
  assign wrBinNext = wrBin + PTR_W'(1);
  assign full      = (wrGrayQ == {~rdGraySync[PTR_W-1 -: 2], rdGraySync[PTR_W-3:0]});

  always_ff @(posedge wrClk or negedge rstN) begin
    if (!rstN) begin
      wrBin   <= '0;
      wrGrayQ <= '0;
    end else if (pushNow) begin
      wrBin   <= wrBinNext;
      wrGrayQ <= wrBinNext ^ (wrBinNext >> 1);
    end
  end

  always_ff @(posedge wrClk or negedge rstN) begin
    if (!rstN)          wrPart <= PART_AE_LO;
    else if (!cfgAccess) wrPart <= PART_AE_LO;
    else if (wrEn)      wrPart <= offPart_e'(wrPart + 2'd1);
  end

  xclk_fifo_sync #(.W(PTR_W), .STAGES(SYNC_LEN)) uRdToWr (
    .clk (wrClk),
    .rstN(rstN),
    .d   (rdGrayQ),
    .q   (rdGraySync)
  );

  // ---------------- read domain ----------------
  xclk_fifo_sync #(.W(PTR_W), .STAGES(SYNC_LEN)) uWrToRd (
    .clk (rdClk),
    .rstN(rstN),
    .d   (wrGrayQ),
    .q   (wrGraySync)
  );

  assign wrBinSync = grayToBin(wrGraySync);
  assign memCount  = wrBinSync - rdBin;
  assign memEmpty  = (memCount == '0);
  assign dataRead  = rdEn && !cfgAccess;
  assign rdBinNext = rdBin + PTR_W'(1);

  always_comb begin
    if (fallThrough) popNow = !memEmpty && (!outValid || dataRead);
    else             popNow = dataRead && !memEmpty;
  end

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN) begin
      rdBin   <= '0;
      rdGrayQ <= '0;
    end else if (popNow) begin
      rdBin   <= rdBinNext;
      rdGrayQ <= rdBinNext ^ (rdBinNext >> 1);
    end
  end

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN)         outValid <= 1'b0;
    else if (popNow)   outValid <= 1'b1;
    else if (dataRead) outValid <= 1'b0;
  end

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN)          rdPart <= PART_AE_LO;
    else if (!cfgAccess) rdPart <= PART_AE_LO;
    else if (rdEn)      rdPart <= offPart_e'(rdPart + 2'd1);
  end

  assign rdReady     = fallThrough ? outValid : !memEmpty;
  assign almostEmpty = (CMP_W'(memCount) <= CMP_W'(aeOffset));

  // ---------------- strobes and outputs ----------------
  always_comb begin
    strobe.push  = pushNow;
    strobe.cfgWr = wrEn && cfgAccess;
    strobe.pop   = popNow;
    strobe.cfgRd = rdEn && cfgAccess;
  end

  assign wrAddr = wrBin[AW-1:0];
  assign rdAddr = rdBin[AW-1:0];
  assign wrPtr  = wrBin;
  assign rdPtr  = rdBin;
  assign wrGray = wrGrayQ;
  assign rdGray = rdGrayQ;

endmodule

// File: rtl/xclk_fifo_datapath.sv
module xclk_fifo_datapath
  import xclk_fifo_pkg::*;
#(
  parameter int DATA_W  = 9,
  parameter int DEPTH   = 1024,
  parameter int AW      = $clog2(DEPTH),
  parameter int AE_INIT = 127,
  parameter int AF_INIT = 127
) (
  input  logic                wrClk,
  input  logic                rdClk,
  input  logic                rstN,
  input  fifoStrobe_t         strobe,
  input  logic [AW-1:0]       wrAddr,
  input  logic [AW-1:0]       rdAddr,
  input  offPart_e            wrPart,
  input  offPart_e            rdPart,
  input  logic [DATA_W-1:0]   wrData,
  output logic [DATA_W-1:0]   headWord,
  output logic [2*DATA_W-1:0] aeOffset
);

  localparam int OFF_W = 2 * DATA_W;
  localparam logic [OFF_W-1:0] AE_RST = OFF_W'(AE_INIT);
  localparam logic [OFF_W-1:0] AF_RST = OFF_W'(AF_INIT);

  logic [DATA_W-1:0] store [DEPTH];
  logic [DATA_W-1:0] offWord [4];
  logic [DATA_W-1:0] qWord, cfgView;
  logic              showCfg;

  // Memory array, write port only; contents need no reset.
  always_ff @(posedge wrClk) begin
    if (strobe.push) store[wrAddr] <= wrData;
  end

  // Offset parts, written from the write domain.
  always_ff @(posedge wrClk or negedge rstN) begin
    if (!rstN) begin
      offWord[PART_AE_LO] <= AE_RST[DATA_W-1:0];
      offWord[PART_AE_HI] <= AE_RST[OFF_W-1:DATA_W];
      offWord[PART_AF_LO] <= AF_RST[DATA_W-1:0];
      offWord[PART_AF_HI] <= AF_RST[OFF_W-1:DATA_W];
    end else if (strobe.cfgWr) begin
      offWord[wrPart] <= wrData;
    end
  end

  // Output register and configuration view, read domain.
  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN) begin
      qWord   <= '0;
      cfgView <= '0;
      showCfg <= 1'b0;
    end else begin
      if (strobe.pop) qWord <= store[rdAddr];
      if (strobe.cfgRd) begin
        cfgView <= offWord[rdPart];
        showCfg <= 1'b1;
      end else if (strobe.pop) begin
        showCfg <= 1'b0;
      end
    end
  end

  assign headWord = showCfg ? cfgView : qWord;
  assign aeOffset = {offWord[PART_AE_HI], offWord[PART_AE_LO]};

endmodule

// File: rtl/xclk_fifo.sv
module xclk_fifo
  import xclk_fifo_pkg::*;
#(
  parameter int DATA_W  = 9,
  parameter int DEPTH   = 1024,
  parameter int AE_INIT = 127,
  parameter int AF_INIT = 127
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              rstN,
  input  logic              fallThrough,
  input  logic              cfgAccess,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdEn,
  input  logic              outEn,
  output logic [DATA_W-1:0] rdData,
  output logic              rdReady,
  output logic              almostEmpty,
  output logic              full
);

  localparam int AW    = $clog2(DEPTH);
  localparam int PTR_W = AW + 1;
  localparam int OFF_W = 2 * DATA_W;

  fifoStrobe_t       strobe;
  logic [AW-1:0]     wrAddr, rdAddr;
  offPart_e          wrPart, rdPart;
  logic [PTR_W-1:0]  wrPtr, rdPtr, wrGray, rdGray, memCount;
  logic [OFF_W-1:0]  aeOffset;
  logic [DATA_W-1:0] headWord;

  xclk_fifo_ctrl #(
    .DEPTH(DEPTH), .AW(AW), .PTR_W(PTR_W), .OFF_W(OFF_W), .SYNC_LEN(2)
  ) uCtrl (
    .wrClk      (wrClk),
    .rdClk      (rdClk),
    .rstN       (rstN),
    .fallThrough(fallThrough),
    .cfgAccess  (cfgAccess),
    .wrEn       (wrEn),
    .rdEn       (rdEn),
    .aeOffset   (aeOffset),
    .strobe     (strobe),
    .wrAddr     (wrAddr),
    .rdAddr     (rdAddr),
    .wrPart     (wrPart),
    .rdPart     (rdPart),
    .wrPtr      (wrPtr),
    .rdPtr      (rdPtr),
    .wrGray     (wrGray),
    .rdGray     (rdGray),
    .memCount   (memCount),
    .full       (full),
    .rdReady    (rdReady),
    .almostEmpty(almostEmpty)
  );

  xclk_fifo_datapath #(
    .DATA_W(DATA_W), .DEPTH(DEPTH), .AW(AW), .AE_INIT(AE_INIT), .AF_INIT(AF_INIT)
  ) uData (
    .wrClk   (wrClk),
    .rdClk   (rdClk),
    .rstN    (rstN),
    .strobe  (strobe),
    .wrAddr  (wrAddr),
    .rdAddr  (rdAddr),
    .wrPart  (wrPart),
    .rdPart  (rdPart),
    .wrData  (wrData),
    .headWord(headWord),
    .aeOffset(aeOffset)
  );

  assign rdData = outEn ? headWord : '0;

endmodule

// File: rtl/xclk_fifo_checker.sv
module xclk_fifo_checker #(
  parameter int PTR_W  = 11,
  parameter int DEPTH  = 1024,
  parameter int DATA_W = 9
) (
  input logic              wrClk,
  input logic              rdClk,
  input logic              rstN,
  input logic              fallThrough,
  input logic              cfgAccess,
  input logic              wrEn,
  input logic              rdEn,
  input logic              full,
  input logic              rdReady,
  input logic [PTR_W-1:0]  wrPtr,
  input logic [PTR_W-1:0]  rdPtr,
  input logic [PTR_W-1:0]  wrGray,
  input logic [PTR_W-1:0]  rdGray,
  input logic [PTR_W-1:0]  memCount,
  input logic [DATA_W-1:0] headWord
);

  // R3: a write at full leaves the write pointer where it was
  p_no_overflow_r3: assert property (@(posedge wrClk) disable iff (!rstN)
    (full && wrEn) |=> $stable(wrPtr));

  // R3: the read-side count never exceeds the depth
  p_count_bound_r3: assert property (@(posedge rdClk) disable iff (!rstN)
    memCount <= PTR_W'(DEPTH));

  // R9: configuration writes never advance the data pointer
  p_cfg_no_push_r9: assert property (@(posedge wrClk) disable iff (!rstN)
    cfgAccess |=> $stable(wrPtr));

  // R2: Gray pointers move by at most one bit per edge
  p_wr_gray_step_r2: assert property (@(posedge wrClk) disable iff (!rstN)
    $countones(wrGray ^ $past(wrGray)) <= 1);

  p_rd_gray_step_r2: assert property (@(posedge rdClk) disable iff (!rstN)
    $countones(rdGray ^ $past(rdGray)) <= 1);

  // R4: no read pointer movement while memory is empty
  p_no_underflow_r4: assert property (@(posedge rdClk) disable iff (!rstN)
    (memCount == '0) |=> $stable(rdPtr));

  // R4: standard mode output holds without a read
  p_std_hold_r4: assert property (@(posedge rdClk) disable iff (!rstN)
    (!fallThrough && !rdEn) |=> $stable(headWord));

  // R5: a fall-through word only appears when memory held one
  p_fwft_source_r5: assert property (@(posedge rdClk) disable iff (!rstN)
    (fallThrough && $rose(rdReady)) |-> ($past(memCount) != '0));

endmodule

bind xclk_fifo xclk_fifo_checker #(
  .PTR_W(PTR_W), .DEPTH(DEPTH), .DATA_W(DATA_W)
) uCheck (
  .wrClk      (wrClk),
  .rdClk      (rdClk),
  .rstN       (rstN),
  .fallThrough(fallThrough),
  .cfgAccess  (cfgAccess),
  .wrEn       (wrEn),
  .rdEn       (rdEn),
  .full       (full),
  .rdReady    (rdReady),
  .wrPtr      (wrPtr),
  .rdPtr      (rdPtr),
  .wrGray     (wrGray),
  .rdGray     (rdGray),
  .memCount   (memCount),
  .headWord   (headWord)
);

// File: tb/tb_xclk_fifo.sv
module tb_xclk_fifo;

  localparam int CLK_PERIOD = 10;
  localparam int RD_HALF    = 7;
  localparam int DEPTH      = 16;
  localparam int AE_OFF     = 5;

  logic       wrClk = 1'b0, rdClk = 1'b0, rstN = 1'b0;
  logic       fallThrough = 1'b0, cfgAccess = 1'b0, wrEn = 1'b0, rdEn = 1'b0, outEn = 1'b1;
  logic [8:0] wrData = '0;
  logic [8:0] rdData;
  logic       rdReady, almostEmpty, full;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) wrClk = ~wrClk;
  always #(RD_HALF) rdClk = ~rdClk;

  xclk_fifo #(.DATA_W(9), .DEPTH(DEPTH), .AE_INIT(127), .AF_INIT(127)) dut (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN), .fallThrough(fallThrough),
    .cfgAccess(cfgAccess), .wrEn(wrEn), .wrData(wrData), .rdEn(rdEn),
    .outEn(outEn), .rdData(rdData), .rdReady(rdReady),
    .almostEmpty(almostEmpty), .full(full)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [8:0] stdVal(input int k);
    return 9'((k * 37 + 3) % 512);
  endfunction

  function automatic logic [8:0] ftVal(input int k);
    return 9'((k * 53 + 11) % 512);
  endfunction

  task automatic settle();
    repeat (5) @(negedge rdClk);
  endtask

  task automatic wrWord(input logic [8:0] v);
    @(negedge wrClk);
    wrEn = 1'b1; wrData = v;
    @(negedge wrClk);
    wrEn = 1'b0;
  endtask

  task automatic applyReset(input logic ft);
    @(negedge wrClk);
    rstN = 1'b0; fallThrough = ft;
    repeat (3) @(negedge rdClk);
    rstN = 1'b1;
    repeat (3) @(negedge rdClk);
  endtask

  // Five consecutive part reads; the fifth shows the wrap to part 0 (R10)
  task automatic readParts(input logic [8:0] p0, input logic [8:0] p1,
                           input logic [8:0] p2, input logic [8:0] p3, input string req);
    logic [8:0] exp [4];
    exp[0] = p0; exp[1] = p1; exp[2] = p2; exp[3] = p3;
    @(negedge rdClk);
    cfgAccess = 1'b1; rdEn = 1'b1;
    for (int k = 0; k < 5; k++) begin
      @(negedge rdClk);
      check((k == 4) ? "R10 wrap" : req, rdData, exp[k % 4]);
    end
    rdEn = 1'b0; cfgAccess = 1'b0;
    @(negedge rdClk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // ---------------- standard mode ----------------
    applyReset(1'b0);
    check("R1 rdReady", rdReady, 0);
    check("R1 full", full, 0);
    check("R1 almostEmpty", almostEmpty, 1);
    check("R1 rdData", rdData, 0);

    readParts(9'd127, 9'd0, 9'd127, 9'd0, "R8 default");

    // R9: program almost-empty offset 5, almost-full offset 9
    @(negedge wrClk);
    cfgAccess = 1'b1; wrEn = 1'b1; wrData = 9'd5;
    @(negedge wrClk); wrData = 9'd0;
    @(negedge wrClk); wrData = 9'd9;
    @(negedge wrClk); wrData = 9'd0;
    @(negedge wrClk); wrEn = 1'b0; cfgAccess = 1'b0;
    settle();
    check("R9 no data entered", rdReady, 0);
    check("R9 flag unchanged", almostEmpty, 1);
    readParts(9'd5, 9'd0, 9'd9, 9'd0, "R9 readback");

    // R10: cfgAccess low between accesses restarts at part 0
    @(negedge rdClk); cfgAccess = 1'b1; rdEn = 1'b1;
    @(negedge rdClk); rdEn = 1'b0; cfgAccess = 1'b0;
    check("R10 first part", rdData, 5);
    @(negedge rdClk); cfgAccess = 1'b1; rdEn = 1'b1;
    @(negedge rdClk); rdEn = 1'b0; cfgAccess = 1'b0;
    check("R10 restart part", rdData, 5);

    // R4: read on empty FIFO is ignored
    @(negedge rdClk); rdEn = 1'b1;
    @(negedge rdClk); rdEn = 1'b0;
    repeat (2) @(negedge rdClk);
    check("R4 empty read ignored", rdData, 5);

    // R6/R7/R3: fill sweep
    for (int k = 1; k <= DEPTH; k++) begin
      wrWord(stdVal(k));
      settle();
      check((k == AE_OFF + 1) ? "R7 crossing" : "R6 threshold", almostEmpty, (k <= AE_OFF) ? 1 : 0);
      check("R4 rdReady", rdReady, 1);
      check("R3 full", full, (k == DEPTH) ? 1 : 0);
    end
    wrWord(9'h1AA);   // dropped (R3)
    settle();
    check("R3 still full", full, 1);

    // R11: configuration read while full consumes nothing
    @(negedge rdClk); cfgAccess = 1'b1; rdEn = 1'b1;
    @(negedge rdClk); rdEn = 1'b0; cfgAccess = 1'b0;
    check("R11 part shown", rdData, 5);
    settle();
    check("R11 no consume", full, 1);

    // R2: drain in order, flag follows reads at once (R7)
    for (int j = 0; j < DEPTH; j++) begin
      @(negedge rdClk); rdEn = 1'b1;
      @(negedge rdClk); rdEn = 1'b0;
      check("R2 order std", rdData, stdVal(j + 1));
      check("R7 read update", almostEmpty, ((DEPTH - 1 - j) <= AE_OFF) ? 1 : 0);
      if (j == 0) begin
        settle();
        check("R3 full released", full, 0);
      end
    end
    check("R4 empty", rdReady, 0);
    @(negedge rdClk); rdEn = 1'b1;
    @(negedge rdClk); rdEn = 1'b0;
    repeat (2) @(negedge rdClk);
    check("R4 hold after empty read", rdData, stdVal(DEPTH));

    outEn = 1'b0;
    @(negedge rdClk);
    check("R12 gated", rdData, 0);
    outEn = 1'b1;
    @(negedge rdClk);
    check("R12 restored", rdData, stdVal(DEPTH));

    // ---------------- fall-through mode ----------------
    applyReset(1'b1);
    check("R1 rdReady ft", rdReady, 0);
    check("R1 almostEmpty ft", almostEmpty, 1);
    readParts(9'd127, 9'd0, 9'd127, 9'd0, "R8 default ft");

    @(negedge wrClk);
    cfgAccess = 1'b1; wrEn = 1'b1; wrData = 9'd5;
    @(negedge wrClk); wrData = 9'd0;
    @(negedge wrClk); wrEn = 1'b0; cfgAccess = 1'b0;
    settle();

    for (int k = 1; k <= DEPTH + 1; k++) begin
      wrWord(ftVal(k));
      settle();
      if (k == 1) begin
        check("R5 fall through ready", rdReady, 1);
        check("R5 fall through data", rdData, ftVal(1));
      end
      check("R6 excl output word", almostEmpty, ((k - 1) <= AE_OFF) ? 1 : 0);
      check("R3 full ft", full, (k == DEPTH + 1) ? 1 : 0);
    end
    wrWord(9'h0F0);   // dropped (R3)
    settle();

    for (int j = 0; j <= DEPTH; j++) begin
      check("R5 ready ft", rdReady, 1);
      check("R2 order ft", rdData, ftVal(j + 1));
      @(negedge rdClk); rdEn = 1'b1;
      @(negedge rdClk); rdEn = 1'b0;
      check("R6 ft after read", almostEmpty,
            (((DEPTH - j - 1) > 0 ? (DEPTH - j - 1) : 0) <= AE_OFF) ? 1 : 0);
    end
    settle();
    check("R5 drained", rdReady, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule